// File: doc/BRIEF.md
# Pileup-Correcting Pulse Energy Extractor

The block takes one filtered 10-bit detector sample per clock and turns each detected pulse into an energy value and a start time. An external detector raises a start flag on the first sample of a pulse. From that sample on, the block sums the incoming samples until a programmable sample window runs out or the next start flag arrives, whichever comes first.

When a new pulse starts while the previous one is still being integrated, the previous pulse's tail is still decaying underneath the new one. The block takes the last sample before the new start as the tail amplitude. It multiplies that amplitude by a cumulative exponential-decay weight, read from a fixed-point table indexed by the number of samples integrated. It then subtracts the product from the new pulse's sum and clamps a negative result to zero. The weighting runs in a three-stage pipeline. The result is offered to a downstream FIFO together with the value that a free-running cycle counter held when the pulse started. Results that meet a full FIFO are discarded and flagged.

Top module: `pue_energy_extractor`

## Requirements
- R1: A free-running 32-bit cycle counter reads 0 in the first cycle after reset and rises by 1 every cycle. Each result carries the counter value of the cycle in which that event's start flag was high.
- R2: An event integrates `start_i`'s sample plus each following sample, and closes once W samples are summed. W is `win_len_i`, with 0 read as 1 and values above `WIN_MAX` read as `WIN_MAX`.
- R3: A start flag during an open event closes that event with the samples summed so far (not the current one) and opens a new event with the current sample in the same cycle.
- R4: The tail amplitude P of an event is the sample of the cycle before its start if the previous event was still open in the start cycle, else 0. Its residual is floor(P·C[n]/65536), where n is the event's sample count, C[n] = e1+…+en, e0 = 65536 and ek = floor(e(k-1)·`DECAY_Q16`/65536).
- R5: The reported energy is the event sum minus its residual, or 0 when the residual is larger.
- R6: An event that closes in cycle c is offered on the output in cycle c+3. An event closed by its window that started in cycle t is therefore offered in cycle t+W+3.
- R7: If `fifo_full_i` is high in the cycle a result is offered, `fifo_wr_o` stays low, the result is lost, and `overflow_o` goes high and stays high until reset.
- R8: While and after reset, `fifo_wr_o` and `overflow_o` are low until an event is offered.
- R9: Each closed event produces exactly one single-cycle write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Event start flag for the current sample |
| sample_i | input | 10 | Filtered unsigned detector sample |
| win_len_i | input | 7 | Integration window in samples |
| fifo_full_i | input | 1 | Downstream FIFO cannot accept a word |
| fifo_wr_o | output | 1 | Write strobe toward the FIFO |
| fifo_energy_o | output | 17 | Corrected event energy |
| fifo_stamp_o | output | 32 | Cycle count at the event start |
| overflow_o | output | 1 | Sticky flag: a result was dropped |

## Verification
The bench builds the block with `WIN_MAX` = 20 and `DECAY_Q16` = 32768, a decay of one half per sample. With that ratio every table entry is exact: C[n] = 65536 − 2^(16−n), so expected residuals can be worked out by hand. The table goes flat at 65535 from n = 16 onward, so a 20-sample pileup exercises the flat end of the table. The small window limit also makes it cheap to drive a window request above the limit and a request of zero, and to check that each is clamped.

// File: rtl/pue_pkg.sv
package pue_pkg;

    localparam int SAMPLE_W  = 10;
    localparam int TS_W      = 32;
    localparam int FRAC_W    = 16;
    localparam int CNT_W     = 7;
    localparam int ACC_W     = SAMPLE_W + CNT_W;
    localparam int CUM_W     = FRAC_W + CNT_W;
    localparam int PROD_W    = SAMPLE_W + CUM_W;
    localparam int LUT_DEPTH = 1 << CNT_W;

    typedef enum logic {
        TRK_IDLE  = 1'b0,
        TRK_INTEG = 1'b1
    } trk_state_e;

    // One closed event as handed from the tracker to the corrector
    typedef struct packed {
        logic [TS_W-1:0]     stamp;
        logic [SAMPLE_W-1:0] tail;
        logic [CNT_W-1:0]    cnt;
        logic [ACC_W-1:0]    sum;
    } evt_rec_t;

    // Corrected result toward the output port
    typedef struct packed {
        logic [TS_W-1:0]  stamp;
        logic [ACC_W-1:0] energy;
    } evt_res_t;

    // Cumulative decay weight: sum over k=1..n of ratio^k, Q16, truncating each step
    function automatic logic [CUM_W-1:0] cum_decay(input int unsigned ratio,
                                                   input int unsigned n);
        longint unsigned w;
        longint unsigned acc;
        w   = 64'd1 << FRAC_W;
        acc = 64'd0;
        for (int unsigned k = 1; k <= n; k++) begin
            w   = (w * longint'(ratio)) >> FRAC_W;
            acc = acc + w;
        end
        return CUM_W'(acc);
    endfunction

endpackage

// File: rtl/pue_event_tracker.sv
module pue_event_tracker
    import pue_pkg::*;
#(
    parameter int WIN_MAX = 63
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [CNT_W-1:0]    win_len_i,
    output logic                close_o,
    output evt_rec_t            rec_o
);

    localparam logic [CNT_W-1:0] WIN_CAP = CNT_W'(WIN_MAX);

    trk_state_e          state_q;
    logic [ACC_W-1:0]    sum_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [TS_W-1:0]     clock_q;
    logic [TS_W-1:0]     stamp_q;
    logic [SAMPLE_W-1:0] tail_q;
    logic [SAMPLE_W-1:0] prev_q;
    logic [CNT_W-1:0]    win_eff;

    always_comb begin
        if (win_len_i == '0)
            win_eff = CNT_W'(1);
        else if (win_len_i > WIN_CAP)
            win_eff = WIN_CAP;
        else
            win_eff = win_len_i;
    end

    assign close_o = (state_q == TRK_INTEG) && (start_i || (cnt_q >= win_eff));
    assign rec_o   = '{stamp: stamp_q, tail: tail_q, cnt: cnt_q, sum: sum_q};

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TRK_IDLE;
            sum_q   <= '0;
            cnt_q   <= '0;
            clock_q <= '0;
            stamp_q <= '0;
            tail_q  <= '0;
            prev_q  <= '0;
        end else begin
            clock_q <= clock_q + 1'b1;
            prev_q  <= sample_i;
            if (start_i) begin
                state_q <= TRK_INTEG;
                sum_q   <= ACC_W'(sample_i);
                cnt_q   <= CNT_W'(1);
                stamp_q <= clock_q;
                tail_q  <= (state_q == TRK_INTEG) ? prev_q : '0;
            end else if (close_o) begin
                state_q <= TRK_IDLE;
            end else if (state_q == TRK_INTEG) begin
                sum_q <= sum_q + ACC_W'(sample_i);
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    // R2: a window close without a new start leaves the tracker idle
    p_idle_after_close_r2: assert property (@(posedge clk) disable iff (rst)
        (close_o && !start_i) |=> (state_q == TRK_IDLE));

    // R3: any start opens an event holding exactly one sample
    p_restart_r3: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (state_q == TRK_INTEG && cnt_q == CNT_W'(1)));

    // R4: an event started from idle carries no tail
    p_fresh_tail_r4: assert property (@(posedge clk) disable iff (rst)
        (start_i && state_q == TRK_IDLE) |=> (tail_q == '0));

    // R1: the start stamp is the counter value of the start cycle
    p_stamp_r1: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (stamp_q == $past(clock_q)));

endmodule

// File: rtl/pue_decay_corrector.sv
module pue_decay_corrector
    import pue_pkg::*;
#(
    parameter int unsigned DECAY_Q16 = 62342
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     v_i,
    input  evt_rec_t rec_i,
    output logic     v_o,
    output evt_res_t res_o
);

    logic [CUM_W-1:0] cum_lut [LUT_DEPTH];

    for (genvar g = 0; g < LUT_DEPTH; g++) begin : g_lut
        assign cum_lut[g] = cum_decay(DECAY_Q16, g);
    end

    // Stage 1: table fetch
    logic                v1_q;
    logic [CUM_W-1:0]    cum1_q;
    logic [SAMPLE_W-1:0] tail1_q;
    logic [ACC_W-1:0]    sum1_q;
    logic [TS_W-1:0]     stamp1_q;
    // Stage 2: weight times tail, back to integer scale
    logic                v2_q;
    logic [ACC_W-1:0]    resid2_q;
    logic [ACC_W-1:0]    sum2_q;
    logic [TS_W-1:0]     stamp2_q;
    // Stage 3: subtract and clamp
    logic                v3_q;
    evt_res_t            res3_q;

    logic [PROD_W-1:0]   prod_c;
    assign prod_c = PROD_W'(tail1_q) * PROD_W'(cum1_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            v1_q     <= 1'b0;
            cum1_q   <= '0;
            tail1_q  <= '0;
            sum1_q   <= '0;
            stamp1_q <= '0;
            v2_q     <= 1'b0;
            resid2_q <= '0;
            sum2_q   <= '0;
            stamp2_q <= '0;
            v3_q     <= 1'b0;
            res3_q   <= '0;
        end else begin
            v1_q     <= v_i;
            cum1_q   <= cum_lut[rec_i.cnt];
            tail1_q  <= rec_i.tail;
            sum1_q   <= rec_i.sum;
            stamp1_q <= rec_i.stamp;

            v2_q     <= v1_q;
            resid2_q <= ACC_W'(prod_c >> FRAC_W);
            sum2_q   <= sum1_q;
            stamp2_q <= stamp1_q;

            v3_q          <= v2_q;
            res3_q.stamp  <= stamp2_q;
            res3_q.energy <= (sum2_q > resid2_q) ? (sum2_q - resid2_q) : '0;
        end
    end

    assign v_o   = v3_q;
    assign res_o = res3_q;

    // R5: the correction never adds energy to an event
    p_no_gain_r5: assert property (@(posedge clk) disable iff (rst)
        v_i |-> ##3 (v_o && (res_o.energy <= $past(rec_i.sum, 3))));

    // R1: the start stamp survives the pipeline unchanged
    p_stamp_kept_r1: assert property (@(posedge clk) disable iff (rst)
        v_i |-> ##3 (res_o.stamp == $past(rec_i.stamp, 3)));

endmodule

// File: rtl/pue_out_port.sv
module pue_out_port
    import pue_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             v_i,
    input  evt_res_t         res_i,
    input  logic             fifo_full_i,
    output logic             fifo_wr_o,
    output logic [ACC_W-1:0] fifo_energy_o,
    output logic [TS_W-1:0]  fifo_stamp_o,
    output logic             overflow_o
);

    logic ovf_q;

    always_ff @(posedge clk) begin
        if (rst)
            ovf_q <= 1'b0;
        else if (v_i && fifo_full_i)
            ovf_q <= 1'b1;
    end

    assign fifo_wr_o     = v_i && !fifo_full_i;
    assign fifo_energy_o = res_i.energy;
    assign fifo_stamp_o  = res_i.stamp;
    assign overflow_o    = ovf_q;

    // R7: the drop flag holds until reset
    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        overflow_o |=> overflow_o);

    // R7: the drop flag only rises after a result met a full FIFO
    p_ovf_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow_o) |-> $past(v_i && fifo_full_i));

endmodule

// File: rtl/pue_energy_extractor.sv
module pue_energy_extractor
    import pue_pkg::*;
#(
    parameter int          WIN_MAX   = 63,
    parameter int unsigned DECAY_Q16 = 62342
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [SAMPLE_W-1:0] sample_i,
    input  logic [CNT_W-1:0]    win_len_i,
    input  logic                fifo_full_i,
    output logic                fifo_wr_o,
    output logic [ACC_W-1:0]    fifo_energy_o,
    output logic [TS_W-1:0]     fifo_stamp_o,
    output logic                overflow_o
);

    logic     trk_close;
    evt_rec_t trk_rec;
    logic     res_v;
    evt_res_t res;

    pue_event_tracker #(.WIN_MAX(WIN_MAX)) i_tracker (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .sample_i  (sample_i),
        .win_len_i (win_len_i),
        .close_o   (trk_close),
        .rec_o     (trk_rec)
    );

    pue_decay_corrector #(.DECAY_Q16(DECAY_Q16)) i_corrector (
        .clk   (clk),
        .rst   (rst),
        .v_i   (trk_close),
        .rec_i (trk_rec),
        .v_o   (res_v),
        .res_o (res)
    );

    pue_out_port i_out (
        .clk           (clk),
        .rst           (rst),
        .v_i           (res_v),
        .res_i         (res),
        .fifo_full_i   (fifo_full_i),
        .fifo_wr_o     (fifo_wr_o),
        .fifo_energy_o (fifo_energy_o),
        .fifo_stamp_o  (fifo_stamp_o),
        .overflow_o    (overflow_o)
    );

    // R6: a closing event reaches the output port three cycles later
    p_latency_r6: assert property (@(posedge clk) disable iff (rst)
        trk_close |-> ##3 res_v);

    // R9: a write strobe never lasts into a full cycle
    p_wr_not_full_r9: assert property (@(posedge clk) disable iff (rst)
        fifo_wr_o |-> !fifo_full_i);

endmodule

// File: tb/test_pue_energy_extractor.sv
`timescale 1ns/1ps
module test_pue_energy_extractor;
    import pue_pkg::*;

    localparam int          TB_WIN_MAX = 20;
    localparam int unsigned TB_DECAY   = 32768;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [9:0]  sample_i = '0;
    logic [6:0]  win_len_i = 7'd8;
    logic        fifo_full_i = 1'b0;
    logic        fifo_wr_o;
    logic [16:0] fifo_energy_o;
    logic [31:0] fifo_stamp_o;
    logic        overflow_o;

    pue_energy_extractor #(.WIN_MAX(TB_WIN_MAX), .DECAY_Q16(TB_DECAY)) i_pue_energy_extractor (
        .clk(clk), .rst(rst), .start_i(start_i), .sample_i(sample_i),
        .win_len_i(win_len_i), .fifo_full_i(fifo_full_i), .fifo_wr_o(fifo_wr_o),
        .fifo_energy_o(fifo_energy_o), .fifo_stamp_o(fifo_stamp_o), .overflow_o(overflow_o)
    );

    always #5 clk = ~clk;

    int     n_run = 0;
    int     n_fail = 0;
    longint tb_cyc = 0;

    // reference for the free-running counter of R1
    always @(posedge clk) tb_cyc <= rst ? 0 : tb_cyc + 1;

    logic [16:0] got_e [64];
    logic [31:0] got_t [64];
    longint      got_c [64];
    int          nwr = 0;

    always @(negedge clk) begin
        if (fifo_wr_o === 1'b1 && nwr < 64) begin
            got_e[nwr] = fifo_energy_o;
            got_t[nwr] = fifo_stamp_o;
            got_c[nwr] = tb_cyc;
            nwr = nwr + 1;
        end
    end

    typedef struct packed {
        logic [9:0]  amp;
        logic [6:0]  hold;
        logic [6:0]  gap;
        logic [16:0] energy;
    } vec_t;

    // window 8, decay one half per sample
    localparam vec_t VEC [6] = '{
        '{10'd100,  7'd8, 7'd4,  17'd800},   // clean window close
        '{10'd200,  7'd3, 7'd0,  17'd600},   // cut short by next start
        '{10'd50,   7'd5, 7'd2,  17'd52},    // tail 200, n=7: 250-198
        '{10'd300,  7'd8, 7'd0,  17'd2400},  // start on window edge, tail 0
        '{10'd10,   7'd2, 7'd10, 17'd0},     // tail 300, 20-298 clamps
        '{10'd1023, 7'd8, 7'd8,  17'd8184}   // full-scale samples
    };
    localparam string VTAG [6] = '{"R2", "R3", "R4", "R3", "R5", "R2"};

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive_event(input int amp, input int hold, input int gap, output longint stamp);
        start_i  = 1'b1;
        sample_i = 10'(amp);
        stamp    = tb_cyc;
        tick();
        start_i = 1'b0;
        for (int i = 1; i < hold; i++) tick();
        sample_i = '0;
        for (int i = 0; i < gap; i++) tick();
    endtask

    initial begin
        #(200000 * 10);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        longint st;
        longint sb;
        longint stamps [6];
        int     base;

        // R8: quiet output during reset
        rst = 1'b1;
        repeat (4) tick();
        check(fifo_wr_o == 1'b0, "R8 wr in reset", longint'(fifo_wr_o), 0);
        check(overflow_o == 1'b0, "R8 ovf in reset", longint'(overflow_o), 0);
        rst = 1'b0;
        tick();
        check(fifo_wr_o == 1'b0 && overflow_o == 1'b0, "R8 after reset",
              longint'({fifo_wr_o, overflow_o}), 0);

        // R6 / R1: exact latency and stamp of a window close
        win_len_i = 7'd5;
        base = nwr;
        drive_event(3, 5, 10, st);
        check(nwr == base + 1, "R9 one write", nwr - base, 1);
        check(got_c[base] == st + 8, "R6 latency", got_c[base], st + 8);
        check(got_e[base] == 17'd15, "R2 sum", longint'(got_e[base]), 15);
        check(longint'(got_t[base]) == st, "R1 stamp", longint'(got_t[base]), st);

        // table walk: pileup patterns at window 8
        win_len_i = 7'd8;
        base = nwr;
        for (int i = 0; i < 6; i++)
            drive_event(int'(VEC[i].amp), int'(VEC[i].hold), int'(VEC[i].gap), stamps[i]);
        repeat (6) tick();
        check(nwr - base == 6, "R9 writes per event", nwr - base, 6);
        for (int i = 0; i < 6; i++) begin
            check(got_e[base+i] == VEC[i].energy, VTAG[i],
                  longint'(got_e[base+i]), longint'(VEC[i].energy));
            check(longint'(got_t[base+i]) == stamps[i], "R1 table stamp",
                  longint'(got_t[base+i]), stamps[i]);
        end

        // R2 / R4: window above the limit, pileup at the flat end of the table
        win_len_i = 7'd100;
        base = nwr;
        drive_event(500, 20, 0, st);
        drive_event(40, 20, 25, sb);
        check(nwr - base == 2, "R9 clamp pair", nwr - base, 2);
        check(got_e[base] == 17'd10000, "R2 clamp window", longint'(got_e[base]), 10000);
        check(got_e[base+1] == 17'd301, "R4 flat table", longint'(got_e[base+1]), 301);
        check(longint'(got_t[base+1]) == sb, "R1 second stamp", longint'(got_t[base+1]), sb);

        // R2: zero window reads as one sample
        win_len_i = 7'd0;
        base = nwr;
        drive_event(7, 1, 3, st);
        repeat (3) tick();
        check(nwr - base == 1, "R2 zero window count", nwr - base, 1);
        check(got_e[base] == 17'd7, "R2 zero window", longint'(got_e[base]), 7);

        // R7: full FIFO drops and latches the flag
        win_len_i = 7'd2;
        fifo_full_i = 1'b1;
        base = nwr;
        drive_event(9, 2, 8, st);
        check(nwr == base, "R7 dropped", nwr - base, 0);
        check(overflow_o == 1'b1, "R7 flag set", longint'(overflow_o), 1);
        fifo_full_i = 1'b0;
        drive_event(11, 2, 8, st);
        repeat (3) tick();
        check(nwr == base + 1, "R7 resumes", nwr - base, 1);
        check(got_e[base] == 17'd22, "R7 resumed value", longint'(got_e[base]), 22);
        check(overflow_o == 1'b1, "R7 sticky", longint'(overflow_o), 1);

        // R8: reset clears the flag
        rst = 1'b1;
        repeat (2) tick();
        rst = 1'b0;
        tick();
        check(overflow_o == 1'b0, "R8 flag cleared", longint'(overflow_o), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule